// File: doc/BRIEF.md
# Tile Name-Entry Pattern Decoder

This block sits in a tilemap fetch path between the name table and pattern memory. It takes three inputs: one 32-bit name-table word, a flag that picks the left or right tile in that word, and the pixel's row and column inside an 8x8 tile. From these it forms the word address of the pattern row that holds the pixel and issues a read to pattern memory in the same cycle. One cycle later, pattern memory returns a 32-bit word. The block takes the pixel value out of that word and joins it with the colour bits from the name entry. The result is a 15-bit palette index, marked valid.

Each request carries a depth flag that selects 4-bit or 8-bit colour. In 4-bit mode a tile is eight words, one word per row, each row holding eight nibbles. The pattern index is the entry rotated so that its top bit becomes the least significant index bit. In 8-bit mode a tile is sixteen words, two words per row, each word holding four bytes. The pattern index is the low fifteen bits of the entry. A new request may be accepted on every cycle.

Top module: `tile_pattern_decoder`

## Requirements
- R1: With `half_sel`=0 the entry used is `name_word[31:16]` (left tile). With `half_sel`=1 it is `name_word[15:0]` (right tile).
- R2: In 4-bit mode (`depth8`=0) the pattern index is {e[13:0], e[15]}, and `mem_addr` is index*8 + row, taken modulo 2^MEM_AW.
- R3: In 8-bit mode (`depth8`=1) the pattern index is e[14:0], and `mem_addr` is index*16 + row*2 + (col div 4), taken modulo 2^MEM_AW.
- R4: In 4-bit mode the pixel at column c is bits [31-4c : 28-4c] of the returned word, so column 0 is the most significant nibble.
- R5: In 8-bit mode the pixel at column c is bits [31-8(c mod 4) : 24-8(c mod 4)] of the returned word, so byte 0 is the most significant byte.
- R6: In 4-bit mode `pal_idx` is {e[14:4], pixel[3:0]}, which equals (e AND 0x7FF0) OR pixel.
- R7: In 8-bit mode `pal_idx` is {e[14:8], pixel[7:0]}, which equals (e AND 0x7F00) OR pixel.
- R8: `mem_rd_en` is high, with `mem_addr` valid, in the same cycle as `in_valid`. `out_valid` is high in the following cycle, and `pal_idx` is formed from the `mem_rdata` present in that cycle.
- R9: A cycle without `in_valid` issues no read, and `out_valid` is low in the next cycle. `out_valid` is low during and right after reset.
- R10: Requests on consecutive cycles are each decoded independently, with no bubble between them and no mixing of state from one request into the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| name_word | input | 32 | Name-table word holding two entries |
| half_sel | input | 1 | 0 selects the left (upper) entry, 1 the right (lower) |
| depth8 | input | 1 | 1 selects 8-bit colour, 0 selects 4-bit colour |
| row | input | 3 | Pixel row inside the tile |
| col | input | 3 | Pixel column inside the tile |
| mem_rd_en | output | 1 | Pattern memory read strobe |
| mem_addr | output | MEM_AW | Pattern memory word address |
| mem_rdata | input | 32 | Pattern word, returned one cycle after the read |
| out_valid | output | 1 | Palette index valid |
| pal_idx | output | 15 | Palette index |

## Verification
The bench builds the block with the default MEM_AW of 18, which addresses a 1 MB pattern space. At this width the 4-bit address uses every bit of the rotated index, while the 8-bit address wraps and drops index bit 14, so both the full-width case and the truncating case are covered. For eight entries that set the MSB, bit 14 and the colour fields in various ways, it sweeps every row and column, both depths and both halves as one continuous back-to-back stream. The entry that is not selected is filled with the complement of the selected one, so a wrong half selection changes the result. Bubble cycles inserted in the stream test that no read is issued and no output appears.

// File: rtl/tpd_pkg.sv
package tpd_pkg;
  localparam int WORD_W  = 32;
  localparam int ENTRY_W = 16;
  localparam int PAL_W   = 15;
  localparam int FULL_AW = 19;

  // Select one of the two entries packed in a name-table word
  function automatic logic [ENTRY_W-1:0] pick_entry(input logic [WORD_W-1:0] w,
                                                    input logic right);
    return right ? w[ENTRY_W-1:0] : w[WORD_W-1:ENTRY_W];
  endfunction

  // Untruncated word address of the pattern word holding a pixel
  function automatic logic [FULL_AW-1:0] tile_word_addr(input logic [ENTRY_W-1:0] e,
                                                        input logic d8,
                                                        input logic [2:0] r,
                                                        input logic [2:0] c);
    if (d8) return {e[14:0], r, c[2]};
    return {1'b0, e[13:0], e[15], r};
  endfunction

  // Join the colour bits of an entry with the pixel value
  function automatic logic [PAL_W-1:0] palette_join(input logic [ENTRY_W-1:0] e,
                                                    input logic d8,
                                                    input logic [7:0] pix);
    if (d8) return {e[14:8], pix};
    return {e[14:4], pix[3:0]};
  endfunction
endpackage

// File: rtl/tpd_addr_gen.sv
module tpd_addr_gen
  import tpd_pkg::*;
#(
  parameter int MEM_AW = 18
) (
  input  logic [WORD_W-1:0]  name_word,
  input  logic               half_sel,
  input  logic               depth8,
  input  logic [2:0]         row,
  input  logic [2:0]         col,
  output logic [ENTRY_W-1:0] entry,
  output logic [MEM_AW-1:0]  addr
);
  logic [FULL_AW-1:0] full_addr;

  always_comb begin
    entry     = pick_entry(name_word, half_sel);
    full_addr = tile_word_addr(entry, depth8, row, col);
    addr      = full_addr[MEM_AW-1:0];
  end
endmodule

// File: rtl/tpd_pixel_join.sv
module tpd_pixel_join
  import tpd_pkg::*;
(
  input  logic [WORD_W-1:0]  rdata,
  input  logic               depth8,
  input  logic [2:0]         col,
  input  logic [ENTRY_W-1:0] entry,
  output logic [PAL_W-1:0]   pal
);
  localparam int NIB_LANES  = WORD_W / 4;
  localparam int BYTE_LANES = WORD_W / 8;

  logic [3:0] nib_lane  [NIB_LANES];
  logic [7:0] byte_lane [BYTE_LANES];
  logic [7:0] pix;

  for (genvar g = 0; g < NIB_LANES; g++) begin : g_nib
    assign nib_lane[g] = rdata[WORD_W-1-4*g -: 4];
  end
  for (genvar g = 0; g < BYTE_LANES; g++) begin : g_byte
    assign byte_lane[g] = rdata[WORD_W-1-8*g -: 8];
  end

  always_comb begin
    pix = depth8 ? byte_lane[col[1:0]] : {4'b0000, nib_lane[col]};
    pal = palette_join(entry, depth8, pix);
  end
endmodule

// File: rtl/tile_pattern_decoder.sv
module tile_pattern_decoder
  import tpd_pkg::*;
#(
  parameter int MEM_AW = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       name_word,
  input  logic              half_sel,
  input  logic              depth8,
  input  logic [2:0]        row,
  input  logic [2:0]        col,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [31:0]       mem_rdata,
  output logic              out_valid,
  output logic [14:0]       pal_idx
);
  logic [ENTRY_W-1:0] sel_entry;
  logic               rd_issue;
  logic               s1_valid;
  logic [ENTRY_W-1:0] s1_entry;
  logic               s1_depth8;
  logic [2:0]         s1_col;

  tpd_addr_gen #(.MEM_AW(MEM_AW)) u_addr (
    .name_word(name_word), .half_sel(half_sel), .depth8(depth8),
    .row(row), .col(col), .entry(sel_entry), .addr(mem_addr)
  );

  assign rd_issue  = in_valid;
  assign mem_rd_en = rd_issue;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_entry  <= '0;
      s1_depth8 <= 1'b0;
      s1_col    <= '0;
    end else begin
      s1_valid <= rd_issue;
      if (rd_issue) begin
        s1_entry  <= sel_entry;
        s1_depth8 <= depth8;
        s1_col    <= col;
      end
    end
  end

  tpd_pixel_join u_join (
    .rdata(mem_rdata), .depth8(s1_depth8), .col(s1_col),
    .entry(s1_entry), .pal(pal_idx)
  );

  assign out_valid = s1_valid;

  AST_ADDR_ROW_4B: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !depth8) |-> (mem_addr[2:0] == row)); // R2
  AST_ADDR_ROW_8B: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && depth8) |-> (mem_addr[3:0] == {row, col[2]})); // R3
  AST_RETURN_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8
  AST_NO_PHANTOM_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R9
  AST_PAL_HIGH_4B: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !depth8) |=> (pal_idx[14:4] == $past(sel_entry[14:4]))); // R6
  AST_PAL_HIGH_8B: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && depth8) |=> (pal_idx[14:8] == $past(sel_entry[14:8]))); // R7
endmodule

// File: tb/tile_pattern_decoder_tb.sv
module tile_pattern_decoder_tb;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [31:0]   name_word = '0;
  logic          half_sel = 1'b0;
  logic          depth8 = 1'b0;
  logic [2:0]    row = '0;
  logic [2:0]    col = '0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_rdata = '0;
  logic          out_valid;
  logic [14:0]   pal_idx;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tile_pattern_decoder #(.MEM_AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .name_word(name_word),
    .half_sel(half_sel), .depth8(depth8), .row(row), .col(col),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .pal_idx(pal_idx)
  );

  function automatic logic [31:0] mem_fn(input int a);
    logic [31:0] v;
    v = a * 32'h9E37_79B1;
    return v ^ {v[15:0], v[31:16]} ^ 32'h5A3C_C3A5;
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) mem_rdata <= mem_fn(int'(mem_addr));

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_addr(input int e, input int d8, input int r, input int c);
    int idx;
    if (d8 != 0) begin
      idx = e % 32768;
      return (idx * 16 + r * 2 + c / 4) % (1 << AW);
    end
    idx = ((e * 2) % 32768) + (e / 32768);
    return (idx * 8 + r) % (1 << AW);
  endfunction

  function automatic int exp_pal(input int e, input int d8, input int c, input logic [31:0] w);
    int px;
    if (d8 != 0) begin
      px = int'((w >> (24 - 8 * (c % 4))) & 32'hFF);
      return (e & 'h7F00) | px;
    end
    px = int'((w >> (28 - 4 * c)) & 32'hF);
    return (e & 'h7FF0) | px;
  endfunction

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int entries [8] = '{'h0000, 'hFFFF, 'h8000, 'h7FFF, 'hA5C3, 'h1234, 'h0001, 'h4000};
    bit pend;
    string preq;
    int pexp;
    int n;
    pend = 0; preq = ""; pexp = 0; n = 0;
    repeat (3) @(negedge clk);
    check("R9 reset out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 post-reset out_valid", int'(out_valid), 0);
    check("R9 idle rd_en", int'(mem_rd_en), 0);
    for (int d = 0; d < 2; d++) begin
      for (int h = 0; h < 2; h++) begin
        for (int k = 0; k < 8; k++) begin
          for (int p = 0; p < 64; p++) begin
            int e, r, c;
            e = entries[k]; r = p / 8; c = p % 8;
            if (pend) begin
              check({preq, " R8 R10 out_valid"}, int'(out_valid), 1);
              check(preq, int'(pal_idx), pexp);
            end
            if ((n % 7) == 6) begin
              in_valid = 1'b0;
              #1;
              check("R9 bubble rd_en", int'(mem_rd_en), 0);
              @(negedge clk);
              check("R9 bubble out_valid", int'(out_valid), 0);
            end
            n++;
            in_valid = 1'b1; depth8 = d[0]; half_sel = h[0];
            row = r[2:0]; col = c[2:0];
            name_word = h ? {~e[15:0], e[15:0]} : {e[15:0], ~e[15:0]};
            #1;
            check("R8 rd_en", int'(mem_rd_en), 1);
            check(d ? "R3 R1 addr 8b" : "R2 R1 addr 4b", int'(mem_addr), exp_addr(e, d, r, c));
            pexp = exp_pal(e, d, c, mem_fn(exp_addr(e, d, r, c)));
            preq = d ? "R7 R5 R1 pal 8b" : "R6 R4 R1 pal 4b";
            pend = 1;
            @(negedge clk);
          end
        end
      end
    end
    check({preq, " R8 out_valid"}, int'(out_valid), 1);
    check(preq, int'(pal_idx), pexp);
    in_valid = 1'b0;
    @(negedge clk);
    check("R9 final out_valid", int'(out_valid), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule